// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Sequencer

This block keeps an asynchronous DRAM array alive by issuing refresh cycles of the column-strobe-first kind, in which the DRAM's internal row counter supplies the address. After reset it holds off for a power-up pause measured in clock cycles. It then requests the memory bus and runs a fixed burst of initialization refresh cycles. Only after that burst does it raise a done flag and let access requests through to the access controller.

Once initialized, a free-running interval timer creates one refresh obligation per interval. Obligations that cannot be serviced at once, because the access controller has not yet granted the bus, accumulate in a saturating counter, so no refresh is lost. The sequencer raises its request while any obligation is outstanding or a cycle is in flight. Whenever the grant is high, it runs back-to-back refresh cycles and places the required ordering on its strobe and write-enable outputs. The access controller multiplexes these outputs onto the DRAM pins while it grants.

All timing is given as parameters in clock cycles. At a 125 MHz clock the defaults give a pause of 100 µs and an interval of 15.2 µs, which keeps 1024 refreshes comfortably inside a 16 ms period.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, ras_n, cas_n and we_n are 1, ref_req is 0, init_done is 0 and acc_req_out is 0.
- R2: ref_req stays 0 for the first PAUSE_CYC - 1 clock edges after reset is released, and is 1 after edge PAUSE_CYC.
- R3: init_done rises only after exactly INIT_CNT refresh cycles have been issued, and then stays 1. acc_req_out is 0 while init_done is 0 and follows acc_req_in afterwards.
- R4: Each refresh cycle starts with cas_n falling while ras_n is 1. ras_n then falls exactly T_CSR cycles later.
- R5: cas_n rises exactly T_CHR cycles after ras_n falls and before ras_n rises. ras_n stays low for exactly T_RAS cycles.
- R6: After ras_n rises, both strobes stay high for at least T_RP + 1 cycles before cas_n falls again.
- R7: we_n is 1 at all times.
- R8: A refresh cycle starts only while ref_gnt is 1. While ref_gnt is 0, an asserted ref_req stays asserted and both strobes stay high.
- R9: After init_done, one refresh obligation is added every INTERVAL_CYC cycles, and each obligation produces exactly one refresh cycle. Obligations not yet serviced are counted up to a saturation limit of 2^PEND_W - 1.
- R10: ref_req is 0 whenever no obligation is outstanding and no refresh cycle is in progress, and both strobes are then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| acc_req_in | input | 1 | Access request from the client side |
| ref_req | output | 1 | Refresh bus request |
| init_done | output | 1 | Power-up pause and initialization burst complete |
| acc_req_out | output | 1 | Access request passed on once initialized |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |

## Verification
The bench builds the block with a 20-cycle pause, a 4-cycle initialization burst, a 200-cycle interval, a 3-bit obligation counter, and strobe windows of 2, 2, 5 and 3 cycles. The short pause lets the pause boundary be checked on every edge. With the 200-cycle interval, a fully saturated backlog of 7 refresh cycles drains well before the next tick. The narrow counter brings saturation into reach: the bench sweeps the number of withheld intervals from 1 to 9 and expects min(m, 7) cycles. A strobe monitor measures every edge-to-edge distance against the parameter values.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CSETUP,
        SQ_RLOW,
        SQ_PRECH
    } sq_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_e;

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int INTERVAL_CYC = 1900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d.cnt = '0;
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = en && (q.cnt == LAST);

endmodule

// File: rtl/rfs_pend_count.sv
module rfs_pend_count #(
    parameter int PEND_W   = 4,
    parameter int INIT_CNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] count
);
    localparam logic [PEND_W-1:0] MAXV  = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] LOADV = PEND_W'(INIT_CNT);

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
    } pend_s;

    pend_s q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = LOADV;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (q.cnt != MAXV) d.cnt = q.cnt + 1'b1;
                2'b01:   if (q.cnt != '0)   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;

endmodule

// File: rtl/rfs_strobe_fsm.sv
module rfs_strobe_fsm
    import rfs_pkg::*;
#(
    parameter int T_CSR = 2,
    parameter int T_CHR = 2,
    parameter int T_RAS = 8,
    parameter int T_RP  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic ras_n,
    output logic cas_n
);
    localparam int CW = $clog2(T_CSR + T_RAS + T_RP + 1);
    localparam logic [CW-1:0] CSR_LAST = CW'(T_CSR - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);
    localparam logic [CW-1:0] CHR_LIM  = CW'(T_CHR);

    typedef struct packed {
        sq_state_e     state;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            SQ_IDLE: begin
                if (start) begin
                    d.state = SQ_CSETUP;
                    d.cnt   = '0;
                end
            end
            SQ_CSETUP: begin
                if (q.cnt == CSR_LAST) begin
                    d.state = SQ_RLOW;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_RLOW: begin
                if (q.cnt == RAS_LAST) begin
                    d.state = SQ_PRECH;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_PRECH: begin
                if (q.cnt == RP_LAST) begin
                    d.state = SQ_IDLE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.state = SQ_IDLE;
                d.cnt   = '0;
            end
        endcase
        // strobes registered from the next state
        d.ras_n = !(d.state == SQ_RLOW);
        d.cas_n = !((d.state == SQ_CSETUP) ||
                    ((d.state == SQ_RLOW) && (d.cnt < CHR_LIM)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= SQ_IDLE;
            q.cnt   <= '0;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign idle  = (q.state == SQ_IDLE);
    assign ras_n = q.ras_n;
    assign cas_n = q.cas_n;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import rfs_pkg::*;
#(
    parameter int PAUSE_CYC    = 12500,
    parameter int INIT_CNT     = 8,
    parameter int INTERVAL_CYC = 1900,
    parameter int PEND_W       = 4,
    parameter int T_CSR        = 2,
    parameter int T_CHR        = 2,
    parameter int T_RAS        = 8,
    parameter int T_RP         = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic acc_req_in,
    output logic ref_req,
    output logic init_done,
    output logic acc_req_out,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);

    typedef struct packed {
        phase_e        phase;
        logic [PW-1:0] pcnt;
    } top_s;

    top_s q, d;

    logic              seq_idle;
    logic              seq_start;
    logic              tick;
    logic              pend_load;
    logic [PEND_W-1:0] pend;

    assign pend_load = (q.phase == PH_PAUSE) && (q.pcnt == PAUSE_LAST);
    assign seq_start = ref_gnt && seq_idle && (pend != '0) && (q.phase != PH_PAUSE);

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_PAUSE: begin
                if (q.pcnt == PAUSE_LAST) begin
                    d.phase = PH_INIT;
                    d.pcnt  = '0;
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                end
            end
            PH_INIT: begin
                if ((pend == '0) && seq_idle) d.phase = PH_RUN;
            end
            PH_RUN:  d.phase = PH_RUN;
            default: d.phase = PH_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_PAUSE;
            q.pcnt  <= '0;
        end else begin
            q <= d;
        end
    end

    rfs_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (q.phase == PH_RUN),
        .tick (tick)
    );

    rfs_pend_count #(
        .PEND_W  (PEND_W),
        .INIT_CNT(INIT_CNT)
    ) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .load (pend_load),
        .inc  (tick),
        .dec  (seq_start),
        .count(pend)
    );

    rfs_strobe_fsm #(
        .T_CSR(T_CSR),
        .T_CHR(T_CHR),
        .T_RAS(T_RAS),
        .T_RP (T_RP)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(seq_start),
        .idle (seq_idle),
        .ras_n(ras_n),
        .cas_n(cas_n)
    );

    assign ref_req     = (pend != '0) || !seq_idle;
    assign init_done   = (q.phase == PH_RUN);
    assign acc_req_out = acc_req_in && init_done;
    assign we_n        = 1'b1;

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic acc_req_in,
    input logic ref_req,
    input logic init_done,
    input logic acc_req_out,
    input logic ras_n,
    input logic cas_n
);
    p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ras_n);

    p_ras_under_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n);

    p_cas_up_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);

    p_start_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ref_gnt);

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_gate_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && acc_req_in) |-> !acc_req_out);

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (ras_n && cas_n));

endmodule

bind dram_refresh_seq rfs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .acc_req_in (acc_req_in),
    .ref_req    (ref_req),
    .init_done  (init_done),
    .acc_req_out(acc_req_out),
    .ras_n      (ras_n),
    .cas_n      (cas_n)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
    localparam int PAUSE = 20;
    localparam int INITN = 4;
    localparam int IVAL  = 200;
    localparam int PW    = 3;
    localparam int TCSR  = 2;
    localparam int TCHR  = 2;
    localparam int TRAS  = 5;
    localparam int TRP   = 3;
    localparam int PMAX  = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic acc_req_in = 1'b0;
    logic ref_req, init_done, acc_req_out, ras_n, cas_n, we_n;

    always #4 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INIT_CNT(INITN), .INTERVAL_CYC(IVAL), .PEND_W(PW),
        .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .acc_req_in(acc_req_in),
        .ref_req(ref_req), .init_done(init_done), .acc_req_out(acc_req_out),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int nref = 0;
    int t_cf = 0;
    int t_rf = 0;
    int t_rr = -1000;
    bit finished = 0;
    logic p_ras = 1'b1;
    logic p_cas = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // strobe monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cas && !cas_n) begin
                nref++;
                t_cf = cyc;
                chk(ras_n == 1'b1, "R4 cas falls with ras high", int'(ras_n), 1);
                chk(ref_gnt == 1'b1, "R8 cycle starts only under grant", int'(ref_gnt), 1);
                chk(we_n == 1'b1, "R7 we_n high", int'(we_n), 1);
                if (t_rr >= 0)
                    chk(cyc - t_rr >= TRP + 1, "R6 precharge before next cas fall", cyc - t_rr, TRP + 1);
            end
            if (p_ras && !ras_n) begin
                t_rf = cyc;
                chk(cyc - t_cf == TCSR, "R4 cas-to-ras delay", cyc - t_cf, TCSR);
            end
            if (!p_cas && cas_n)
                chk(cyc - t_rf == TCHR, "R5 cas hold after ras fall", cyc - t_rf, TCHR);
            if (!p_ras && ras_n) begin
                t_rr = cyc;
                chk(cyc - t_rf == TRAS, "R5 ras low width", cyc - t_rf, TRAS);
            end
            if (!we_n) chk(1'b0, "R7 we_n low seen", 0, 1);
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        int tlist[4];
        acc_req_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!ref_req, "R1 no request in reset", int'(ref_req), 0);
        chk(!init_done && !acc_req_out, "R1 done and gate low in reset", {init_done, acc_req_out}, 0);
        rst_n = 1'b1;
        // R2 pause boundary on every edge
        for (int n = 1; n <= PAUSE; n++) begin
            @(posedge clk); @(negedge clk);
            chk(ref_req == (n >= PAUSE), "R2 request after pause", int'(ref_req), int'(n >= PAUSE));
        end
        // R8 request held, strobes quiet without grant
        repeat (5) begin
            @(negedge clk);
            chk(ref_req && ras_n && cas_n, "R8 held request, quiet strobes", {ref_req, ras_n, cas_n}, 7);
        end
        chk(!init_done && !acc_req_out, "R3 gate closed before init", {init_done, acc_req_out}, 0);
        ref_gnt = 1'b1;
        for (int k = 0; k < 500 && !init_done; k++) @(negedge clk);
        chk(nref == INITN, "R3 init burst length", nref, INITN);
        chk(acc_req_out == 1'b1, "R3 gate open after init", int'(acc_req_out), 1);
        acc_req_in = 1'b0;
        @(negedge clk);
        chk(acc_req_out == 1'b0, "R3 gate follows input", int'(acc_req_out), 0);
        ref_gnt = 1'b0;
        chk(!ref_req, "R10 request drops when nothing owed", int'(ref_req), 0);
        // R9 backlog sweep with saturation
        for (int m = 1; m <= 9; m++) begin
            for (int k = 0; k < IVAL + 10 && !ref_req; k++) @(negedge clk);
            repeat ((m - 1) * IVAL + 20) @(negedge clk);
            base = nref;
            ref_gnt = 1'b1;
            @(negedge clk);
            for (int k = 0; k < 300 && ref_req; k++) @(negedge clk);
            ref_gnt = 1'b0;
            chk(!ref_req && ras_n && cas_n, "R10 idle after drain", {ref_req, ras_n, cas_n}, 3);
            chk(nref - base == ((m < PMAX) ? m : PMAX), "R9 backlog count", nref - base,
                (m < PMAX) ? m : PMAX);
        end
        // R9 interval spacing with grant held
        ref_gnt = 1'b1;
        for (int i = 0; i < 4; i++) begin
            base = nref;
            for (int k = 0; k < IVAL * 2 && nref == base; k++) @(negedge clk);
            tlist[i] = t_cf;
        end
        for (int i = 1; i < 4; i++)
            chk(tlist[i] - tlist[i-1] == IVAL, "R9 refresh spacing", tlist[i] - tlist[i-1], IVAL);
        chk(init_done == 1'b1, "R3 done stays high", int'(init_done), 1);
        chk(we_n == 1'b1, "R7 we_n high at end", int'(we_n), 1);
        finish_run();
    end
endmodule